// File: doc/BRIEF.md
# Per-Device Chip-Select Timing Sequencer

This block sits beside the shift engine of a serial-peripheral master that talks to up to five devices. It owns the select lines and the clock-enable. When a request names a device, it asserts that device's select line and holds the clock back for a programmable setup interval. It then lets the shifter run. After the final bit it waits a programmable hold interval and drops the select. From that point it keeps the same device locked out for a programmable minimum deselect interval.

Each device has a packed 32-bit timing word. The timing counts are in units of a prescaler period of `TICK_DIV` system clocks. When gaps are enabled, the hold count also sets an optional pause between bytes. A sixth selection runs the clock phases without asserting any line. The select idle level and the data idle level are chosen per request. Illegal level codes and illegal selections are refused.

The shifter sees a level enable and a start pulse. It reports each shifted bit back on a bit-done strobe, with a last-bit flag on the final bit.

Top module: `cst_seq`

## Requirements
- R1: After reset every select line is high, `sclk_en_o`, `busy_o`, `ack_o`, `reject_o` and `data_idle_o` are low.
- R2: The timing word of device d sits in `param_i[32*d +: 32]` with these fields: bits 31:24 clock-rate value, 23:16 setup count, 15:8 hold count, 7:0 deselect count. While device d is being served, `clk_rate_o` shows its clock-rate value.
- R3: `sclk_en_o` and the one-cycle `start_o` pulse rise max(1, setup*TICK_DIV) cycles after the select goes active.
- R4: A bit-done strobe with the last-bit flag drops `sclk_en_o` in the next cycle. The select (and `busy_o`) goes inactive max(1, hold*TICK_DIV) cycles after that. The select does not change while the clock is enabled.
- R5: Once a device's select goes inactive, a request for that same device that is held pending is accepted so that the line stays inactive for exactly deselect*TICK_DIV+1 cycles. No acknowledge is given earlier.
- R6: A device's deselect lockout does not delay a request for a different device. That request is accepted in the first idle cycle, and its select is active one cycle after it was sampled.
- R7: With the gap enable set and a non-zero hold count, the clock is withheld for hold*TICK_DIV cycles after every eighth bit that is not the last. With the gap enable clear, or a zero hold count, the clock stays enabled across byte boundaries.
- R8: Selection code 5 (dummy) asserts no line. It runs setup and hold with zero counts: one cycle each.
- R9: Level code 0 means idle low and code 1 means idle high, for both the select and the data idle level. An active select is the inverse of its idle level, and `data_idle_o` shows the data level of the accepted request.
- R10: A request with a level code of 2 or 3, or a selection code of 6 or 7, gives a one-cycle `reject_o` pulse in the cycle after it is sampled. It changes neither a select line nor the clock enable.
- R11: `ack_o` pulses for one cycle, in the first cycle the select is active. At most one select line is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| param_i | input | 32*NUM_DEV | Packed per-device timing words |
| req_i | input | 1 | Transfer request, held until ack or reject |
| dev_sel_i | input | SEL_W | Device selection; NUM_DEV means dummy |
| gap_en_i | input | 1 | Enable the inter-byte gap |
| cs_idle_lvl_i | input | 2 | Select idle level code |
| data_idle_lvl_i | input | 2 | Data idle level code |
| bit_done_i | input | 1 | Shifter finished one bit |
| last_bit_i | input | 1 | Qualifies bit_done_i as the final bit |
| ack_o | output | 1 | Request accepted |
| reject_o | output | 1 | Request refused |
| busy_o | output | 1 | Transfer in progress |
| cs_o | output | NUM_DEV | Select lines |
| sclk_en_o | output | 1 | Clock release to the shifter |
| start_o | output | 1 | First cycle of clock release |
| clk_rate_o | output | 8 | Clock-rate value of the served device |
| data_idle_o | output | 1 | Data line idle level |

## Verification
The checks assume a well-behaved shifter and requester, and the stimulus is built to respect each assumption:
- Bit-done strobes arrive only while the clock is enabled, and the last-bit flag is set only together with a strobe. The stimulus waits for `sclk_en_o` before every strobe and raises each strobe for a single cycle.
- A request and its selection and level inputs stay steady until `ack_o` or `reject_o`. All inputs change on the falling clock edge, and the request is dropped in the cycle the answer is seen, so it is never sampled twice.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef struct packed {
    logic [7:0] rate;
    logic [7:0] setup;
    logic [7:0] hold;
    logic [7:0] idle_dly;
  } dev_param_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RUN, ST_GAP, ST_HOLD
  } phase_e;
endpackage

// File: rtl/cst_wait.sv
module cst_wait #(
  parameter int TW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rem_q <= '0;
    else if (load_i)        rem_q <= val_i;
    else if (rem_q != '0)   rem_q <= rem_q - 1'b1;
  end

  // phase lasts max(1, val) cycles
  assign done_o = (rem_q <= TW'(1));
endmodule

// File: rtl/cst_guard.sv
module cst_guard #(
  parameter int NUM_DEV = 5,
  parameter int TW      = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DEV-1:0] release_i,
  input  logic [TW-1:0]      val_i,
  output logic [NUM_DEV-1:0] blocked_o
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic [TW-1:0] rem_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               rem_q <= '0;
      else if (release_i[g])     rem_q <= val_i;
      else if (rem_q != '0)      rem_q <= rem_q - 1'b1;
    end
    assign blocked_o[g] = (rem_q != '0);
  end
endmodule

// File: rtl/cst_ctrl.sv
module cst_ctrl
  import cst_pkg::*;
#(
  parameter int NUM_DEV  = 5,
  parameter int TICK_DIV = 4,
  parameter int SEL_W    = 3,
  parameter int TW       = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [32*NUM_DEV-1:0] param_i,
  input  logic                 req_i,
  input  logic [SEL_W-1:0]     dev_sel_i,
  input  logic                 gap_en_i,
  input  logic [1:0]           cs_idle_lvl_i,
  input  logic [1:0]           data_idle_lvl_i,
  input  logic                 bit_done_i,
  input  logic                 last_bit_i,
  input  logic [NUM_DEV-1:0]   blocked_i,
  input  logic                 wait_done_i,
  output logic                 load_o,
  output logic [TW-1:0]        load_val_o,
  output logic [NUM_DEV-1:0]   release_o,
  output logic [TW-1:0]        guard_val_o,
  output logic                 ack_o,
  output logic                 reject_o,
  output logic                 start_o,
  output logic                 busy_o,
  output logic                 sclk_en_o,
  output logic                 sel_act_o,
  output logic [SEL_W-1:0]     dev_o,
  output logic                 cs_idle_o,
  output logic                 data_idle_o,
  output logic [7:0]           clk_rate_o
);
  localparam int SEL_N = 1 << SEL_W;

  function automatic logic [TW-1:0] to_cyc(input logic [7:0] cnt);
    return TW'(cnt) * TW'(TICK_DIV);
  endfunction

  dev_param_t prm [NUM_DEV];
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_prm
    assign prm[g] = param_i[32*g +: 32];
  end

  phase_e           state_q, state_d;
  logic [7:0]       rate_q, hold_q, dly_q;
  logic             dummy_q, gap_q, cs_idle_q, data_idle_q;
  logic [SEL_W-1:0] dev_q;
  logic [2:0]       bit_q;
  logic             ack_q, rej_q, start_q;

  logic             sel_dev, sel_dummy, lvl_ok, req_go, req_bad;
  logic [SEL_N-1:0] blk_ext;
  dev_param_t       sel_prm;

  assign blk_ext   = SEL_N'(blocked_i);
  assign sel_dev   = dev_sel_i < SEL_W'(NUM_DEV);
  assign sel_dummy = dev_sel_i == SEL_W'(NUM_DEV);
  assign lvl_ok    = !cs_idle_lvl_i[1] && !data_idle_lvl_i[1];
  assign req_go    = req_i && lvl_ok && (sel_dummy || (sel_dev && !blk_ext[dev_sel_i]));
  assign req_bad   = req_i && !(lvl_ok && (sel_dev || sel_dummy));

  always_comb begin
    sel_prm = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (dev_sel_i == SEL_W'(i)) sel_prm = prm[i];
  end

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    release_o  = '0;
    unique case (state_q)
      ST_IDLE: if (req_go) begin
        state_d = ST_SETUP; load_o = 1'b1; load_val_o = to_cyc(sel_prm.setup);
      end
      ST_SETUP: if (wait_done_i) state_d = ST_RUN;
      ST_RUN: if (bit_done_i) begin
        if (last_bit_i) begin
          state_d = ST_HOLD; load_o = 1'b1; load_val_o = to_cyc(hold_q);
        end else if (bit_q == 3'd7 && gap_q && hold_q != 8'd0) begin
          state_d = ST_GAP; load_o = 1'b1; load_val_o = to_cyc(hold_q);
        end
      end
      ST_GAP: if (wait_done_i) state_d = ST_RUN;
      ST_HOLD: if (wait_done_i) begin
        state_d = ST_IDLE;
        for (int i = 0; i < NUM_DEV; i++)
          if (!dummy_q && dev_q == SEL_W'(i)) release_o[i] = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rate_q      <= '0;
      hold_q      <= '0;
      dly_q       <= '0;
      dummy_q     <= 1'b0;
      gap_q       <= 1'b0;
      cs_idle_q   <= 1'b1;
      data_idle_q <= 1'b0;
      dev_q       <= '0;
      bit_q       <= '0;
      ack_q       <= 1'b0;
      rej_q       <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_q == ST_IDLE) && req_go;
      rej_q   <= (state_q == ST_IDLE) && req_bad;
      start_q <= (state_q == ST_SETUP) && wait_done_i;
      if (state_q == ST_IDLE && req_go) begin
        rate_q      <= sel_prm.rate;
        hold_q      <= sel_prm.hold;
        dly_q       <= sel_prm.idle_dly;
        dummy_q     <= sel_dummy;
        dev_q       <= dev_sel_i;
        gap_q       <= gap_en_i;
        cs_idle_q   <= cs_idle_lvl_i[0];
        data_idle_q <= data_idle_lvl_i[0];
        bit_q       <= '0;
      end else if (state_q == ST_RUN && bit_done_i) begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign guard_val_o = to_cyc(dly_q);
  assign ack_o       = ack_q;
  assign reject_o    = rej_q;
  assign start_o     = start_q;
  assign busy_o      = state_q != ST_IDLE;
  assign sclk_en_o   = state_q == ST_RUN;
  assign sel_act_o   = (state_q != ST_IDLE) && !dummy_q;
  assign dev_o       = dev_q;
  assign cs_idle_o   = cs_idle_q;
  assign data_idle_o = data_idle_q;
  assign clk_rate_o  = rate_q;
endmodule

// File: rtl/cst_seq.sv
module cst_seq #(
  parameter int NUM_DEV  = 5,
  parameter int TICK_DIV = 4,
  parameter int SEL_W    = $clog2(NUM_DEV + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [32*NUM_DEV-1:0] param_i,
  input  logic                  req_i,
  input  logic [SEL_W-1:0]      dev_sel_i,
  input  logic                  gap_en_i,
  input  logic [1:0]            cs_idle_lvl_i,
  input  logic [1:0]            data_idle_lvl_i,
  input  logic                  bit_done_i,
  input  logic                  last_bit_i,
  output logic                  ack_o,
  output logic                  reject_o,
  output logic                  busy_o,
  output logic [NUM_DEV-1:0]    cs_o,
  output logic                  sclk_en_o,
  output logic                  start_o,
  output logic [7:0]            clk_rate_o,
  output logic                  data_idle_o
);
  localparam int TW = 8 + $clog2(TICK_DIV + 1);

  logic               load, wait_done, sel_act, cs_idle_w;
  logic [TW-1:0]      load_val, guard_val;
  logic [NUM_DEV-1:0] release_v, blocked;
  logic [SEL_W-1:0]   dev;

  cst_wait #(.TW(TW)) u_wait (
    .clk_i, .rst_ni, .load_i(load), .val_i(load_val), .done_o(wait_done)
  );

  cst_guard #(.NUM_DEV(NUM_DEV), .TW(TW)) u_guard (
    .clk_i, .rst_ni, .release_i(release_v), .val_i(guard_val), .blocked_o(blocked)
  );

  cst_ctrl #(.NUM_DEV(NUM_DEV), .TICK_DIV(TICK_DIV), .SEL_W(SEL_W), .TW(TW)) u_ctrl (
    .clk_i, .rst_ni, .param_i, .req_i, .dev_sel_i, .gap_en_i,
    .cs_idle_lvl_i, .data_idle_lvl_i, .bit_done_i, .last_bit_i,
    .blocked_i(blocked), .wait_done_i(wait_done),
    .load_o(load), .load_val_o(load_val), .release_o(release_v),
    .guard_val_o(guard_val), .ack_o, .reject_o, .start_o, .busy_o,
    .sclk_en_o, .sel_act_o(sel_act), .dev_o(dev), .cs_idle_o(cs_idle_w),
    .data_idle_o, .clk_rate_o
  );

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_cs
    assign cs_o[g] = (sel_act && dev == SEL_W'(g)) ? ~cs_idle_w : cs_idle_w;
  end
endmodule

// File: rtl/cst_seq_chk.sv
module cst_seq_chk #(
  parameter int NUM_DEV = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_DEV-1:0] cs_o,
  input logic               cs_idle,
  input logic               sclk_en_o,
  input logic               busy_o,
  input logic               ack_o,
  input logic               reject_o,
  input logic               start_o
);
  a_r11_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ {NUM_DEV{cs_idle}}) <= 1);

  a_r11_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> busy_o && !reject_o);

  a_r10_reject_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !busy_o && !sclk_en_o);

  a_r3_start_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> sclk_en_o);

  a_r4_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_en_o && $past(sclk_en_o)) |-> $stable(cs_o));

  a_r4_clk_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_o |-> busy_o);
endmodule

bind cst_seq cst_seq_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk_i, .rst_ni, .cs_o, .cs_idle(cs_idle_w), .sclk_en_o, .busy_o,
  .ack_o, .reject_o, .start_o
);

// File: tb/cst_seq_bench.sv
module cst_seq_bench;
  localparam int ND = 5;
  localparam int TD = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [32*ND-1:0] param;
  logic          req = 0, gap_en = 0, bit_done = 0, last_bit = 0;
  logic [2:0]    sel = 0;
  logic [1:0]    cl = 1, dl = 0;
  logic          ack, rej, busy, sclk_en, start, data_idle;
  logic [ND-1:0] cs;
  logic [7:0]    rate;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  int s_cnt [ND+1] = '{2, 0, 1, 3, 1, 0};
  int h_cnt [ND+1] = '{3, 0, 2, 1, 1, 0};
  int d_cnt [ND+1] = '{5, 10, 0, 2, 1, 0};
  int r_val [ND+1] = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 0};

  always #2.5 clk = ~clk;

  cst_seq #(.NUM_DEV(ND), .TICK_DIV(TD)) u_cst_seq (
    .clk_i(clk), .rst_ni(rst_n), .param_i(param), .req_i(req), .dev_sel_i(sel),
    .gap_en_i(gap_en), .cs_idle_lvl_i(cl), .data_idle_lvl_i(dl),
    .bit_done_i(bit_done), .last_bit_i(last_bit), .ack_o(ack), .reject_o(rej),
    .busy_o(busy), .cs_o(cs), .sclk_en_o(sclk_en), .start_o(start),
    .clk_rate_o(rate), .data_idle_o(data_idle)
  );

  function automatic int mx1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [ND-1:0] idle_vec(logic lvl);
    return {ND{lvl}};
  endfunction

  // raise request, wait for ack or reject; k = cycles until answer
  task automatic issue(int s, bit g, logic [1:0] c, logic [1:0] d, output int k);
    sel = 3'(s); gap_en = g; cl = c; dl = d; req = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!(ack || rej));
    req = 1'b0;
  endtask

  // called in the first cycle of an accepted transfer
  task automatic body(int s, bit g, int nbits, logic lvl);
    int n, gc;
    logic [ND-1:0] exp_cs;
    exp_cs = idle_vec(lvl);
    if (s < ND) exp_cs[s] = ~lvl;
    check("R11 select on ack", int'(cs), int'(exp_cs));
    if (s < ND) check("R2 clk rate", int'(rate), r_val[s]);
    n = 0;
    while (!sclk_en) begin @(negedge clk); n++; end
    check("R3 setup cycles", n, mx1(s_cnt[s] * TD));
    check("R3 start pulse", int'(start), 1);
    for (int b = 0; b < nbits; b++) begin
      while (!sclk_en) @(negedge clk);
      bit_done = 1'b1; last_bit = (b == nbits - 1);
      @(negedge clk);
      bit_done = 1'b0; last_bit = 1'b0;
      if (b != nbits - 1 && (b % 8) == 7) begin
        gc = 0;
        while (!sclk_en) begin @(negedge clk); gc++; end
        check("R7 byte gap", gc, (g && h_cnt[s] != 0) ? h_cnt[s] * TD : 0);
      end
    end
    check("R4 clk off after last", int'(sclk_en), 0);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    check("R4 hold cycles", n, mx1(h_cnt[s] * TD));
    check("R4 select released", int'(cs), int'(idle_vec(lvl)));
  endtask

  task automatic t_reset();
    check("R1 cs", int'(cs), int'(idle_vec(1'b1)));
    check("R1 sclk_en", int'(sclk_en), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 ack/reject", int'({ack, rej}), 0);
    check("R1 data idle", int'(data_idle), 0);
  endtask

  task automatic t_basic();
    int k;
    issue(0, 0, 2'd1, 2'd0, k);
    check("R6 first accept", k, 1);
    body(0, 0, 8, 1'b1);
    issue(2, 0, 2'd1, 2'd0, k);
    body(2, 0, 3, 1'b1);
  endtask

  task automatic t_guard();
    int k;
    issue(0, 0, 2'd1, 2'd0, k);
    body(0, 0, 4, 1'b1);
    issue(0, 0, 2'd1, 2'd0, k); // R5 held off by deselect lockout
    check("R5 inactive cycles", k, d_cnt[0] * TD + 1);
    body(0, 0, 2, 1'b1);
    issue(1, 0, 2'd1, 2'd0, k);
    body(1, 0, 1, 1'b1);
    issue(2, 0, 2'd1, 2'd0, k);
    check("R6 other device free", k, 1);
    body(2, 0, 1, 1'b1);
  endtask

  task automatic t_gap();
    int k;
    issue(0, 1, 2'd1, 2'd0, k);
    body(0, 1, 24, 1'b1);
    issue(4, 0, 2'd1, 2'd0, k);
    body(4, 0, 17, 1'b1);
    issue(1, 1, 2'd1, 2'd0, k);
    body(1, 1, 16, 1'b1);
  endtask

  task automatic t_dummy();
    int k;
    issue(ND, 0, 2'd1, 2'd0, k);
    check("R8 dummy accepted", int'(ack), 1);
    body(ND, 0, 5, 1'b1);
  endtask

  task automatic t_levels();
    int k;
    issue(3, 0, 2'd0, 2'd1, k);
    check("R9 data idle level", int'(data_idle), 1);
    body(3, 0, 3, 1'b0);
    check("R9 cs idle low", int'(cs), 0);
    repeat (TD * d_cnt[3] + 2) @(negedge clk);
    issue(3, 0, 2'd1, 2'd0, k);
    body(3, 0, 2, 1'b1);
    check("R9 data idle back", int'(data_idle), 0);
  endtask

  task automatic t_reject();
    int k;
    issue(6, 0, 2'd1, 2'd0, k);
    check("R10 bad select latency", k, 1);
    check("R10 bad select", int'({rej, busy, sclk_en}), 3'b100);
    check("R10 cs untouched", int'(cs), int'(idle_vec(1'b1)));
    @(negedge clk);
    check("R10 single pulse", int'(rej), 0);
    issue(1, 0, 2'd2, 2'd0, k);
    check("R10 bad level", int'({rej, busy, ack}), 3'b100);
    check("R10 cs untouched 2", int'(cs), int'(idle_vec(1'b1)));
    @(negedge clk);
  endtask

  initial begin
    for (int d = 0; d < ND; d++)
      param[32*d +: 32] = {8'(r_val[d]), 8'(s_cnt[d]), 8'(h_cnt[d]), 8'(d_cnt[d])};
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_guard();
    t_gap();
    t_dummy();
    repeat (60) @(negedge clk);
    t_levels();
    t_reject();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule